// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block is the software-visible register file of an interrupt router. Software reaches it through two bus offsets. One is an 8-bit select register. The other is a 32-bit data window whose meaning depends on the select value. Behind the window are three registers: a read-only version word, a writable 4-bit identifier, and an arbitration word that reads back that identifier. Behind it also sits a table of 64-bit redirection entries, one per input pin, each reached as a lower and an upper 32-bit half.

The block decodes the select value and merges half-entry writes into the stored entry. It protects two status bits, delivery-in-progress and remote-acknowledge-pending, from software writes. The delivery engine outside the block drives those bits through set and clear strobes. Every field of every entry is exported as flat vectors for that engine. When a software write flips an entry's mask bit, the block emits a one-cycle event carrying the pin number and the new mask value.

Top module: `irq_route_regs`

## Requirements
- R1: A bus write at offset 0x00 stores write data bits 7:0 as the select value; a bus read at offset 0x00 returns that value zero-extended to 32 bits.
- R2: Read data appears on `acc_rdata` one cycle after the read access and holds until the next read; offsets other than 0x00 and 0x10 read as zero, and writes to them change no state.
- R3: With select 0x01 the window reads {8'h00, PINS-1, 8'h00, VERSION}; window writes with that select are ignored.
- R4: With select 0x00 a window write keeps data bits 27:24 as the identifier; a window read returns it in bits 27:24 with all other bits zero.
- R5: With select 0x02 the window reads the same value as select 0x00, and a window write changes nothing.
- R6: Any other select addresses the table at index ((select - 0x10) mod 256) >> 1; an even select accesses entry bits 31:0, an odd select accesses bits 63:32, and a write leaves the other half unchanged.
- R7: A table index of PINS or above reads as 32'hFFFFFFFF, and a window write to it changes no entry.
- R8: Entry bit 12 (delivery status) and bit 14 (remote pending) ignore window write data. Only the per-pin set and clear strobes change them, and set wins over clear.
- R9: After a window write that leaves bit 15 (trigger, 1 = level) at 0, the entry's bit 14 is 0, even if a set strobe arrives in the same cycle.
- R10: Entry fields are exported continuously: vector bits 7:0, delivery mode 10:8, destination mode 11, delivery status 12, remote pending 14, trigger 15, mask 16, destination 63:56.
- R11: A window write that changes an entry's mask bit makes `mask_evt` high for exactly the next cycle, with `mask_evt_pin` equal to the entry index and `mask_evt_val` equal to the new mask. A write that leaves the mask unchanged raises no event.
- R12: After reset every entry reads 64'h0000_0000_0001_0000 (mask set, all else zero), and the select, the identifier and `acc_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Bus access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | 8 | Byte offset: 0x00 select, 0x10 window |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| rirr_set | input | PINS | Set remote-pending bit per pin |
| rirr_clr | input | PINS | Clear remote-pending bit per pin |
| dsts_set | input | PINS | Set delivery-status bit per pin |
| dsts_clr | input | PINS | Clear delivery-status bit per pin |
| ent_vector | output | 8*PINS | Vector of each entry |
| ent_dmode | output | 3*PINS | Delivery mode of each entry |
| ent_destmode | output | PINS | Destination mode per entry |
| ent_dsts | output | PINS | Delivery status per entry |
| ent_remote | output | PINS | Remote pending per entry |
| ent_level | output | PINS | Trigger mode per entry (1 = level) |
| ent_mask | output | PINS | Mask per entry |
| ent_dest | output | 8*PINS | Destination of each entry |
| mask_evt | output | 1 | Mask-change event pulse |
| mask_evt_pin | output | clog2(PINS) | Entry index of the event |
| mask_evt_val | output | 1 | New mask value of the event |

## Verification
Entry registers, the select, the identifier and the event flop all load at the clock edge that samples the access. Exported fields and `mask_evt` are therefore valid from the first falling edge after that edge. Read data is registered in the same way, so a read issued on one falling edge is compared on the next. Each bus task drives on a falling edge and returns on the following one. Field outputs and the one-cycle event are compared right at that point, before any further access can move them. Status strobes are held for exactly one cycle, and their effect is read back through the window on the following access.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int ENT_W  = 64;
  localparam int WORD_W = 32;

  // bus offsets
  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;

  // select values
  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_ARB = 8'h02;
  localparam logic [7:0] SEL_TAB = 8'h10;

  // entry bit positions
  localparam int B_VEC_LO  = 0;
  localparam int B_DMODE   = 8;
  localparam int B_DSTMODE = 11;
  localparam int B_DSTS    = 12;
  localparam int B_RIRR    = 14;
  localparam int B_LEVEL   = 15;
  localparam int B_MASK    = 16;
  localparam int B_DEST    = 56;

  localparam logic [ENT_W-1:0] ENT_RST = 64'h0000_0000_0001_0000;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_SEL,
    RD_VER,
    RD_ID,
    RD_TAB,
    RD_ONES
  } rd_kind_t;

  function automatic logic [7:0] tab_index(input logic [7:0] sel);
    logic [7:0] d;
    d = sel - SEL_TAB;
    return {1'b0, d[7:1]};
  endfunction

  function automatic logic [ENT_W-1:0] merge_half(input logic [ENT_W-1:0] old,
                                                   input logic [WORD_W-1:0] data,
                                                   input logic hi);
    return hi ? {data, old[WORD_W-1:0]} : {old[ENT_W-1:WORD_W], data};
  endfunction

  function automatic logic [WORD_W-1:0] version_word(input logic [7:0] max_pin,
                                                     input logic [7:0] ver);
    return {8'h00, max_pin, 8'h00, ver};
  endfunction

  function automatic logic [WORD_W-1:0] id_word(input logic [3:0] id);
    return {4'h0, id, 24'h0};
  endfunction

endpackage

// File: rtl/irq_route_slot.sv
module irq_route_slot
  import irq_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rirr_set,
  input  logic              rirr_clr,
  input  logic              dsts_set,
  input  logic              dsts_clr,
  output logic [ENT_W-1:0]  ent_q,
  output logic              mask_chg,
  output logic              mask_new
);

  logic [ENT_W-1:0] ent_r;
  logic [ENT_W-1:0] merged;
  logic [ENT_W-1:0] nxt;

  always_comb begin
    merged = merge_half(ent_r, wdata, wr_hi);
    nxt    = wr_en ? merged : ent_r;
    // status bits never follow write data
    if (dsts_set)      nxt[B_DSTS] = 1'b1;
    else if (dsts_clr) nxt[B_DSTS] = 1'b0;
    else               nxt[B_DSTS] = ent_r[B_DSTS];
    if (rirr_set)      nxt[B_RIRR] = 1'b1;
    else if (rirr_clr) nxt[B_RIRR] = 1'b0;
    else               nxt[B_RIRR] = ent_r[B_RIRR];
    // an entry written into edge mode drops any pending acknowledge
    if (wr_en && !nxt[B_LEVEL]) nxt[B_RIRR] = 1'b0;
    mask_chg = wr_en && (nxt[B_MASK] != ent_r[B_MASK]);
    mask_new = nxt[B_MASK];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ent_r <= ENT_RST;
    else        ent_r <= nxt;
  end

  assign ent_q = ent_r;

endmodule

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int PINS = 24
) (
  input  logic            acc_en,
  input  logic            acc_wr,
  input  logic [7:0]      acc_off,
  input  logic [7:0]      sel_q,
  output logic            sel_wr,
  output logic            id_wr,
  output logic [PINS-1:0] slot_wr,
  output logic            slot_hi,
  output logic [7:0]      tab_idx,
  output rd_kind_t        rd_kind
);

  localparam logic [7:0] PIN_LIM = 8'(PINS);

  logic in_range;
  logic is_reg;
  logic win_wr;

  always_comb begin
    tab_idx  = tab_index(sel_q);
    slot_hi  = sel_q[0];
    in_range = tab_idx < PIN_LIM;
    is_reg   = (sel_q == SEL_ID) || (sel_q == SEL_VER) || (sel_q == SEL_ARB);
    win_wr   = acc_en && acc_wr && (acc_off == OFF_WIN);
    sel_wr   = acc_en && acc_wr && (acc_off == OFF_SEL);
    id_wr    = win_wr && (sel_q == SEL_ID);
    for (int i = 0; i < PINS; i++)
      slot_wr[i] = win_wr && !is_reg && in_range && (tab_idx == 8'(i));

    if (acc_off == OFF_SEL) rd_kind = RD_SEL;
    else if (acc_off == OFF_WIN) begin
      if (sel_q == SEL_VER)                          rd_kind = RD_VER;
      else if (sel_q == SEL_ID || sel_q == SEL_ARB)  rd_kind = RD_ID;
      else if (in_range)                             rd_kind = RD_TAB;
      else                                           rd_kind = RD_ONES;
    end
    else rd_kind = RD_ZERO;
  end

endmodule

// File: rtl/irq_route_rdmux.sv
module irq_route_rdmux
  import irq_route_pkg::*;
#(
  parameter int          PINS    = 24,
  parameter logic [7:0]  VERSION = 8'h11
) (
  input  rd_kind_t                    rd_kind,
  input  logic [7:0]                  tab_idx,
  input  logic                        slot_hi,
  input  logic [7:0]                  sel_q,
  input  logic [3:0]                  id_q,
  input  logic [PINS-1:0][ENT_W-1:0]  table_q,
  output logic [WORD_W-1:0]           rd_word
);

  localparam logic [7:0] MAX_PIN = 8'(PINS - 1);

  logic [ENT_W-1:0] ent_sel;

  always_comb begin
    ent_sel = '0;
    for (int i = 0; i < PINS; i++)
      if (tab_idx == 8'(i)) ent_sel = table_q[i];
  end

  always_comb begin
    unique case (rd_kind)
      RD_SEL:  rd_word = {24'h0, sel_q};
      RD_VER:  rd_word = version_word(MAX_PIN, VERSION);
      RD_ID:   rd_word = id_word(id_q);
      RD_TAB:  rd_word = slot_hi ? ent_sel[ENT_W-1:WORD_W] : ent_sel[WORD_W-1:0];
      RD_ONES: rd_word = '1;
      default: rd_word = '0;
    endcase
  end

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int         PINS    = 24,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_en,
  input  logic                      acc_wr,
  input  logic [7:0]                acc_off,
  input  logic [31:0]               acc_wdata,
  output logic [31:0]               acc_rdata,
  input  logic [PINS-1:0]           rirr_set,
  input  logic [PINS-1:0]           rirr_clr,
  input  logic [PINS-1:0]           dsts_set,
  input  logic [PINS-1:0]           dsts_clr,
  output logic [PINS*8-1:0]         ent_vector,
  output logic [PINS*3-1:0]         ent_dmode,
  output logic [PINS-1:0]           ent_destmode,
  output logic [PINS-1:0]           ent_dsts,
  output logic [PINS-1:0]           ent_remote,
  output logic [PINS-1:0]           ent_level,
  output logic [PINS-1:0]           ent_mask,
  output logic [PINS*8-1:0]         ent_dest,
  output logic                      mask_evt,
  output logic [$clog2(PINS)-1:0]   mask_evt_pin,
  output logic                      mask_evt_val
);

  localparam int PIN_W = $clog2(PINS);

  logic [7:0]                 sel_q;
  logic [3:0]                 id_q;
  logic                       sel_wr;
  logic                       id_wr;
  logic [PINS-1:0]            slot_wr;
  logic                       slot_hi;
  logic [7:0]                 tab_idx;
  rd_kind_t                   rd_kind;
  logic [PINS-1:0][ENT_W-1:0] table_q;
  logic [PINS-1:0]            mask_chg;
  logic [PINS-1:0]            mask_new;
  logic [WORD_W-1:0]          rd_word;
  logic [PIN_W-1:0]           chg_pin;
  logic                       chg_val;

  irq_route_decode #(.PINS(PINS)) u_dec (
    .acc_en  (acc_en),
    .acc_wr  (acc_wr),
    .acc_off (acc_off),
    .sel_q   (sel_q),
    .sel_wr  (sel_wr),
    .id_wr   (id_wr),
    .slot_wr (slot_wr),
    .slot_hi (slot_hi),
    .tab_idx (tab_idx),
    .rd_kind (rd_kind)
  );

  for (genvar g = 0; g < PINS; g++) begin : g_slot
    irq_route_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (slot_wr[g]),
      .wr_hi    (slot_hi),
      .wdata    (acc_wdata),
      .rirr_set (rirr_set[g]),
      .rirr_clr (rirr_clr[g]),
      .dsts_set (dsts_set[g]),
      .dsts_clr (dsts_clr[g]),
      .ent_q    (table_q[g]),
      .mask_chg (mask_chg[g]),
      .mask_new (mask_new[g])
    );

    assign ent_vector[g*8 +: 8]  = table_q[g][B_VEC_LO +: 8];
    assign ent_dmode[g*3 +: 3]   = table_q[g][B_DMODE +: 3];
    assign ent_destmode[g]       = table_q[g][B_DSTMODE];
    assign ent_dsts[g]           = table_q[g][B_DSTS];
    assign ent_remote[g]         = table_q[g][B_RIRR];
    assign ent_level[g]          = table_q[g][B_LEVEL];
    assign ent_mask[g]           = table_q[g][B_MASK];
    assign ent_dest[g*8 +: 8]    = table_q[g][B_DEST +: 8];
  end

  irq_route_rdmux #(.PINS(PINS), .VERSION(VERSION)) u_rd (
    .rd_kind (rd_kind),
    .tab_idx (tab_idx),
    .slot_hi (slot_hi),
    .sel_q   (sel_q),
    .id_q    (id_q),
    .table_q (table_q),
    .rd_word (rd_word)
  );

  // at most one slot is written per cycle, so a plain scan encodes it
  always_comb begin
    chg_pin = '0;
    chg_val = 1'b0;
    for (int i = 0; i < PINS; i++)
      if (mask_chg[i]) begin
        chg_pin = PIN_W'(i);
        chg_val = mask_new[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q        <= '0;
      id_q         <= '0;
      acc_rdata    <= '0;
      mask_evt     <= 1'b0;
      mask_evt_pin <= '0;
      mask_evt_val <= 1'b0;
    end else begin
      if (sel_wr) sel_q <= acc_wdata[7:0];
      if (id_wr)  id_q  <= acc_wdata[27:24];
      if (acc_en && !acc_wr) acc_rdata <= rd_word;
      mask_evt     <= |mask_chg;
      mask_evt_pin <= chg_pin;
      mask_evt_val <= chg_val;
    end
  end

endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
  parameter int PINS = 24
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    acc_en,
  input logic                    acc_wr,
  input logic [7:0]              acc_off,
  input logic [31:0]             acc_wdata,
  input logic [7:0]              sel_q,
  input logic [3:0]              id_q,
  input logic [PINS-1:0]         slot_wr,
  input logic [PINS-1:0]         rirr_set,
  input logic [PINS-1:0]         dsts_set,
  input logic [PINS-1:0]         dsts_clr,
  input logic [PINS-1:0]         ent_level,
  input logic [PINS-1:0]         ent_remote,
  input logic [PINS-1:0]         ent_dsts,
  input logic [PINS-1:0]         ent_mask,
  input logic                    mask_evt,
  input logic [$clog2(PINS)-1:0] mask_evt_pin,
  input logic                    mask_evt_val
);

  logic unused_ok;
  assign unused_ok = ^{acc_wdata[31:28], acc_wdata[23:8], rirr_set};

  a_r1_sel_store: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_off == 8'h00) |=> (sel_q == $past(acc_wdata[7:0])));

  a_r2_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_off != 8'h00 && acc_off != 8'h10)
      |=> ($stable(sel_q) && $stable(id_q) && $stable(ent_mask)));

  a_r4_id_store: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_off == 8'h10 && sel_q == 8'h00)
      |=> (id_q == $past(acc_wdata[27:24])));

  a_r5_arb_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_off == 8'h10 && sel_q == 8'h02) |=> $stable(id_q));

  a_r6_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_wr));

  a_r11_evt_source: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt |-> $past(|slot_wr));

  a_r11_evt_value: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt |-> (ent_mask[mask_evt_pin] == mask_evt_val));

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    a_r9_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
      slot_wr[g] |=> (ent_level[g] || !ent_remote[g]));

    a_r8_dsts_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_wr[g] && !dsts_set[g] && !dsts_clr[g]) |=> $stable(ent_dsts[g]));
  end

endmodule

bind irq_route_regs irq_route_regs_chk #(.PINS(PINS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_en       (acc_en),
  .acc_wr       (acc_wr),
  .acc_off      (acc_off),
  .acc_wdata    (acc_wdata),
  .sel_q        (sel_q),
  .id_q         (id_q),
  .slot_wr      (slot_wr),
  .rirr_set     (rirr_set),
  .dsts_set     (dsts_set),
  .dsts_clr     (dsts_clr),
  .ent_level    (ent_level),
  .ent_remote   (ent_remote),
  .ent_dsts     (ent_dsts),
  .ent_mask     (ent_mask),
  .mask_evt     (mask_evt),
  .mask_evt_pin (mask_evt_pin),
  .mask_evt_val (mask_evt_val)
);

// File: tb/irq_route_regs_test.sv
module irq_route_regs_test;

  localparam int PINS = 24;
  localparam int PW   = $clog2(PINS);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              acc_en = 1'b0;
  logic              acc_wr = 1'b0;
  logic [7:0]        acc_off = '0;
  logic [31:0]       acc_wdata = '0;
  logic [31:0]       acc_rdata;
  logic [PINS-1:0]   rirr_set = '0, rirr_clr = '0, dsts_set = '0, dsts_clr = '0;
  logic [PINS*8-1:0] ent_vector, ent_dest;
  logic [PINS*3-1:0] ent_dmode;
  logic [PINS-1:0]   ent_destmode, ent_dsts, ent_remote, ent_level, ent_mask;
  logic              mask_evt, mask_evt_val;
  logic [PW-1:0]     mask_evt_pin;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  irq_route_regs #(.PINS(PINS), .VERSION(8'h11)) uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_off(acc_off), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .rirr_set(rirr_set), .rirr_clr(rirr_clr), .dsts_set(dsts_set), .dsts_clr(dsts_clr),
    .ent_vector(ent_vector), .ent_dmode(ent_dmode), .ent_destmode(ent_destmode),
    .ent_dsts(ent_dsts), .ent_remote(ent_remote), .ent_level(ent_level),
    .ent_mask(ent_mask), .ent_dest(ent_dest), .mask_evt(mask_evt),
    .mask_evt_pin(mask_evt_pin), .mask_evt_val(mask_evt_val)
  );

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] off, logic [31:0] data);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_off = off; acc_wdata = data;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] off, output logic [31:0] data);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_off = off;
    @(negedge clk);
    acc_en = 1'b0;
    data = acc_rdata;
  endtask

  task automatic win_rd(logic [7:0] sel, output logic [31:0] data);
    bus_wr(8'h00, {24'h0, sel});
    bus_rd(8'h10, data);
  endtask

  task automatic win_wr(logic [7:0] sel, logic [31:0] data);
    bus_wr(8'h00, {24'h0, sel});
    bus_wr(8'h10, data);
  endtask

  function automatic logic [7:0] lo_sel(int idx);
    return 8'(8'h10 + 2 * idx);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check("R12 mask after reset", ent_mask, {PINS{1'b1}});
    check("R12 rdata after reset", acc_rdata, 0);
    bus_rd(8'h00, d);
    check("R12 select after reset", d, 0);
    bus_rd(8'h10, d);
    check("R12 id after reset", d, 0);
    win_rd(lo_sel(0), d);
    check("R12 entry0 low after reset", d, 32'h0001_0000);
    win_rd(8'(lo_sel(PINS-1) + 1), d);
    check("R12 last entry high after reset", d, 0);
  endtask

  task automatic t_select_version();
    logic [31:0] d;
    bus_wr(8'h00, 32'h1234_5677);
    bus_rd(8'h00, d);
    check("R1 select keeps low byte", d, 32'h77);
    win_rd(8'h01, d);
    check("R3 version word", d, {8'h0, 8'(PINS-1), 8'h0, 8'h11});
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_rd(8'h10, d);
    check("R3 version ignores write", d, {8'h0, 8'(PINS-1), 8'h0, 8'h11});
  endtask

  task automatic t_ident();
    logic [31:0] d;
    win_wr(8'h00, 32'hAB00_00FF);
    bus_rd(8'h10, d);
    check("R4 id from bits 27:24", d, 32'h0B00_0000);
    win_rd(8'h02, d);
    check("R5 arbitration reads id", d, 32'h0B00_0000);
    bus_wr(8'h10, 32'h0500_0000);
    win_rd(8'h00, d);
    check("R5 arbitration write no effect", d, 32'h0B00_0000);
  endtask

  task automatic t_stray();
    logic [31:0] d;
    bus_wr(8'h00, 32'h02);
    bus_wr(8'h20, 32'h55);
    bus_rd(8'h20, d);
    check("R2 stray offset reads zero", d, 0);
    bus_rd(8'h00, d);
    check("R2 stray write keeps select", d, 32'h02);
    bus_rd(8'h10, d);
    check("R2 stray write keeps id", d, 32'h0B00_0000);
  endtask

  task automatic t_table();
    logic [31:0] d;
    win_wr(lo_sel(3), 32'h0000_DB45);
    check("R11 pulse on unmask", mask_evt, 1);
    check("R11 pulse pin", mask_evt_pin, 3);
    check("R11 pulse value", mask_evt_val, 0);
    check("R10 vector", ent_vector[3*8 +: 8], 8'h45);
    check("R10 delivery mode", ent_dmode[3*3 +: 3], 3'd3);
    check("R10 dest mode", ent_destmode[3], 1);
    check("R10 level", ent_level[3], 1);
    check("R10 mask", ent_mask[3], 0);
    bus_rd(8'h10, d);
    check("R8 status bits ignore write", d, 32'h0000_8B45);
    win_wr(8'(lo_sel(3) + 1), 32'hC300_0000);
    check("R11 no pulse on high write", mask_evt, 0);
    check("R10 destination", ent_dest[3*8 +: 8], 8'hC3);
    bus_rd(8'h10, d);
    check("R6 high half readback", d, 32'hC300_0000);
    win_rd(lo_sel(3), d);
    check("R6 low half preserved", d, 32'h0000_8B45);
  endtask

  task automatic t_status();
    logic [31:0] d;
    @(negedge clk); rirr_set[3] = 1'b1;
    @(negedge clk); rirr_set[3] = 1'b0;
    check("R8 remote set by strobe", ent_remote[3], 1);
    bus_wr(8'h10, 32'h0000_8B45);
    bus_rd(8'h10, d);
    check("R8 remote survives write", d, 32'h0000_CB45);
    @(negedge clk); dsts_set[3] = 1'b1; dsts_clr[3] = 1'b1;
    @(negedge clk); dsts_set[3] = 1'b0; dsts_clr[3] = 1'b0;
    bus_rd(8'h10, d);
    check("R8 set wins over clear", d, 32'h0000_DB45);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_off = 8'h10; acc_wdata = 32'h0000_0B45;
    rirr_set[3] = 1'b1;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; rirr_set[3] = 1'b0;
    check("R9 edge write clears remote", ent_remote[3], 0);
    check("R8 delivery status kept", ent_dsts[3], 1);
    bus_rd(8'h10, d);
    check("R9 readback after edge write", d, 32'h0000_1B45);
    @(negedge clk); dsts_clr[3] = 1'b1;
    @(negedge clk); dsts_clr[3] = 1'b0;
    check("R8 delivery status cleared", ent_dsts[3], 0);
  endtask

  task automatic t_range();
    logic [31:0] d;
    logic [PINS-1:0] m0;
    m0 = ent_mask;
    win_rd(lo_sel(PINS), d);
    check("R7 first index past end", d, 32'hFFFF_FFFF);
    win_rd(8'(lo_sel(PINS) + 1), d);
    check("R7 high half past end", d, 32'hFFFF_FFFF);
    win_rd(8'h05, d);
    check("R7 select below table", d, 32'hFFFF_FFFF);
    win_wr(lo_sel(PINS), 32'h0);
    check("R7 no event on discarded write", mask_evt, 0);
    check("R7 masks unchanged", ent_mask, m0);
    win_rd(lo_sel(0), d);
    check("R7 entry0 untouched", d, 32'h0001_0000);
  endtask

  task automatic t_pulse();
    win_wr(lo_sel(5), 32'h0001_0020);
    check("R11 no pulse when mask kept", mask_evt, 0);
    bus_wr(8'h10, 32'h0000_0020);
    check("R11 pulse pin5", {mask_evt, 8'(mask_evt_pin), mask_evt_val}, {1'b1, 8'd5, 1'b0});
    @(negedge clk);
    check("R11 pulse lasts one cycle", mask_evt, 0);
    win_wr(lo_sel(PINS-1), 32'h0000_0011);
    check("R11 pulse last pin", {mask_evt, 8'(mask_evt_pin), mask_evt_val},
          {1'b1, 8'(PINS-1), 1'b0});
    bus_wr(8'h10, 32'h0001_0011);
    check("R11 pulse on re-mask", {mask_evt, mask_evt_val}, 2'b11);
    check("R10 mask output follows", ent_mask[PINS-1], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select_version();
    t_ident();
    t_stray();
    t_table();
    t_status();
    t_range();
    t_pulse();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule